// File: doc/BRIEF.md
# USB Endpoint Buffer Handshake Controller

This block keeps the firmware-facing buffer state of a USB device's endpoints. Endpoints 0 and 1 form the control pair (0 receives, 1 transmits) and are always enabled. Every other endpoint is configured by firmware through a chain of configuration writes that fill the registers one after another. For each endpoint the block tracks whether its buffer holds a packet and whether an interrupt is pending. It answers the packet engine with an accept or a NAK.

Firmware works through a one-cycle command port. It can read an endpoint's status, which also clears its interrupt. It can free a receive buffer, release a written transmit buffer for sending, or acknowledge a SETUP. A SETUP on endpoint 0 locks the free and release commands on both control endpoints until firmware acknowledges it. This keeps the SETUP bytes in place and stops any reply from going out before firmware has seen the request.

Top module: `ep_handshake_ctrl`

## Requirements
- R1: After `rst_ni` is asserted or `bus_reset_i` is pulsed, every endpoint from 2 upward reads disabled with an empty buffer and no interrupt. Endpoints 0 and 1 read enabled and empty. `irq_o` is low, the configuration write pointer is back at register 0, and any SETUP lock is released.
- R2: Each `cfg_we_i` pulse writes `cfg_data_i` into the register at the write pointer and then advances the pointer, which wraps from NUM_EP-1 back to 0. In `cfg_data_i`, bit 0 is the enable and bit 1 is the direction (1 = transmit). Writes that land on registers 0 and 1 change nothing. A write with enable 0 also empties the endpoint and drops its interrupt.
- R3: A packet event on an enabled receive endpoint whose buffer is empty is accepted: the buffer becomes full and the interrupt is set. When the buffer is already full, `nak_o` is high in that cycle and nothing changes.
- R4: A Clear command (op 2) empties an enabled receive endpoint, after which the next packet is accepted.
- R5: A Validate command (op 3) marks an enabled transmit buffer full. A packet event on a full transmit endpoint is accepted: the buffer becomes empty and the interrupt is set. A transmit endpoint that has not been validated answers with `nak_o`.
- R6: A SETUP event (`sie_setup_i` with endpoint 0) is always accepted, even when endpoint 0 is full. It fills endpoint 0, sets its interrupt, empties endpoint 1 and sets the SETUP lock.
- R7: While the lock is held, Clear and Validate commands on endpoints 0 and 1 have no effect. An Acknowledge command (op 4) releases the lock.
- R8: `status_o` continuously shows {enabled, interrupt, full} in bits 2, 1 and 0 for the endpoint `cmd_ep_i` selects. A Read command (op 1) clears that endpoint's interrupt at the next clock edge.
- R9: When an accepted packet event and a Read command hit the same endpoint in the same cycle, the interrupt stays set.
- R10: On a disabled endpoint, commands have no effect, and packet events get `nak_o` without setting an interrupt.
- R11: `irq_o` is high exactly when at least one endpoint interrupt is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_reset_i | input | 1 | USB bus reset seen on the line, one-cycle pulse |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_data_i | input | 2 | {direction, enable} written at the pointer |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | 1 read, 2 clear, 3 validate, 4 acknowledge SETUP |
| cmd_ep_i | input | IDX_W | Command / status endpoint index |
| status_o | output | 3 | {enabled, interrupt, full} of `cmd_ep_i` |
| sie_valid_i | input | 1 | Packet engine event strobe |
| sie_ep_i | input | IDX_W | Event endpoint index |
| sie_setup_i | input | 1 | Event is a SETUP packet |
| nak_o | output | 1 | Event is refused (valid with `sie_valid_i`) |
| int_o | output | NUM_EP | Per-endpoint interrupt flags |
| irq_o | output | 1 | OR of all interrupt flags |

## Verification
The bench builds the block with NUM_EP = 4. This leaves one configurable receive endpoint and one configurable transmit endpoint next to the control pair. The configuration pointer then wraps after four writes, so the bench can reach the wrap, disabling, and re-enabling without long write runs. Two things are run as directed sequences rather than table rows: the same-cycle event-and-read collision, and a bus reset taken while the SETUP lock is held.

// File: rtl/hs_pkg.sv
`timescale 1ns/1ps
package hs_pkg;
  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_READ     = 3'd1,
    OP_CLEAR    = 3'd2,
    OP_VALIDATE = 3'd3,
    OP_ACK      = 3'd4
  } hs_op_e;

  typedef struct packed {
    logic dir_in;
    logic en;
  } ep_cfg_t;

  localparam int unsigned STAT_W = 3;
endpackage

// File: rtl/hs_cfg_seq.sv
`timescale 1ns/1ps
module hs_cfg_seq #(
  parameter int unsigned NUM_EP = 16,
  localparam int unsigned IDX_W = $clog2(NUM_EP)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             we_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_EP - 1);

  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ptr_q <= '0;
    else if (flush_i)      ptr_q <= '0;
    else if (we_i)         ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/hs_setup_lock.sv
`timescale 1ns/1ps
module hs_setup_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic setup_i,
  input  logic ack_i,
  output logic lock_o
);
  logic lock_q;

  // a SETUP in the same cycle as an acknowledge wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lock_q <= 1'b0;
    else if (flush_i) lock_q <= 1'b0;
    else if (setup_i) lock_q <= 1'b1;
    else if (ack_i)   lock_q <= 1'b0;
  end

  assign lock_o = lock_q;

  // R6
  setup_locks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setup_i && !flush_i) |=> lock_o);
endmodule

// File: rtl/hs_ep_cell.sv
`timescale 1ns/1ps
module hs_ep_cell
  import hs_pkg::*;
#(
  parameter bit FIXED    = 1'b0,
  parameter bit FIXED_IN = 1'b0
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    flush_i,
  input  logic    cfg_wr_i,
  input  ep_cfg_t cfg_data_i,
  input  logic    clear_i,
  input  logic    validate_i,
  input  logic    read_i,
  input  logic    event_i,
  input  logic    setup_i,
  input  logic    flush_in_i,
  output logic    en_o,
  output logic    full_o,
  output logic    int_o,
  output logic    nak_o
);
  logic en_q, dir_q, full_q, int_q;
  logic en, dir_in, accept, cfg_kill;

  assign en       = FIXED ? 1'b1 : en_q;
  assign dir_in   = FIXED ? FIXED_IN : dir_q;
  assign nak_o    = !en || (dir_in ? !full_q : full_q);
  assign accept   = event_i && !nak_o;
  assign cfg_kill = cfg_wr_i && !FIXED && !cfg_data_i.en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      dir_q <= 1'b0;
    end else if (flush_i) begin
      en_q  <= 1'b0;
      dir_q <= 1'b0;
    end else if (cfg_wr_i && !FIXED) begin
      en_q  <= cfg_data_i.en;
      dir_q <= cfg_data_i.dir_in;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           full_q <= 1'b0;
    else if (flush_i || cfg_kill)          full_q <= 1'b0;
    else if (setup_i)                      full_q <= 1'b1;
    else if (flush_in_i)                   full_q <= 1'b0;
    else if (accept)                       full_q <= !dir_in;
    else if (clear_i && en && !dir_in)     full_q <= 1'b0;
    else if (validate_i && en && dir_in)   full_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  int_q <= 1'b0;
    else if (flush_i || cfg_kill) int_q <= 1'b0;
    else if (setup_i || accept)   int_q <= 1'b1;
    else if (read_i)              int_q <= 1'b0;
  end

  assign en_o   = en;
  assign full_o = full_q;
  assign int_o  = int_q;

  // R9
  ev_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i && !nak_o && !flush_i && !cfg_wr_i) |=> int_q);

  // R10
  off_no_int_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !int_q);

  // R3
  refuse_keeps_buf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i && nak_o && !flush_i && !cfg_wr_i && !setup_i && !flush_in_i
     && !clear_i && !validate_i) |=> $stable(full_q));
endmodule

// File: rtl/ep_handshake_ctrl.sv
`timescale 1ns/1ps
module ep_handshake_ctrl
  import hs_pkg::*;
#(
  parameter int unsigned NUM_EP = 16,
  localparam int unsigned IDX_W = $clog2(NUM_EP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_reset_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_data_i,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [IDX_W-1:0]  cmd_ep_i,
  output logic [STAT_W-1:0] status_o,
  input  logic              sie_valid_i,
  input  logic [IDX_W-1:0]  sie_ep_i,
  input  logic              sie_setup_i,
  output logic              nak_o,
  output logic [NUM_EP-1:0] int_o,
  output logic              irq_o
);
  logic [IDX_W-1:0]  cfg_ptr;
  logic              lock;
  logic              setup_ev;
  logic              ack_cmd;
  logic [NUM_EP-1:0] en_v, full_v, int_v, nak_v;

  assign setup_ev = sie_valid_i && sie_setup_i && (sie_ep_i == '0);
  assign ack_cmd  = cmd_valid_i && (cmd_op_i == OP_ACK);

  hs_cfg_seq #(.NUM_EP(NUM_EP)) i_cfg_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (bus_reset_i),
    .we_i    (cfg_we_i),
    .ptr_o   (cfg_ptr)
  );

  hs_setup_lock i_setup_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (bus_reset_i),
    .setup_i (setup_ev),
    .ack_i   (ack_cmd),
    .lock_o  (lock)
  );

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    localparam bit IS_CTRL = (g < 2);
    logic hit, blocked, ev;

    assign hit     = cmd_valid_i && (cmd_ep_i == IDX_W'(g));
    assign blocked = IS_CTRL && lock;
    assign ev      = sie_valid_i && !setup_ev && (sie_ep_i == IDX_W'(g));

    hs_ep_cell #(.FIXED(IS_CTRL), .FIXED_IN(g == 1)) i_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .flush_i    (bus_reset_i),
      .cfg_wr_i   (cfg_we_i && (cfg_ptr == IDX_W'(g))),
      .cfg_data_i (ep_cfg_t'(cfg_data_i)),
      .clear_i    (hit && (cmd_op_i == OP_CLEAR) && !blocked),
      .validate_i (hit && (cmd_op_i == OP_VALIDATE) && !blocked),
      .read_i     (hit && (cmd_op_i == OP_READ)),
      .event_i    (ev),
      .setup_i    ((g == 0) ? setup_ev : 1'b0),
      .flush_in_i ((g == 1) ? setup_ev : 1'b0),
      .en_o       (en_v[g]),
      .full_o     (full_v[g]),
      .int_o      (int_v[g]),
      .nak_o      (nak_v[g])
    );
  end

  assign status_o = {en_v[cmd_ep_i], int_v[cmd_ep_i], full_v[cmd_ep_i]};
  assign nak_o    = sie_valid_i && !setup_ev && nak_v[sie_ep_i];
  assign int_o    = int_v;
  assign irq_o    = |int_v;

  // R7
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |-> (full_v[0] && !full_v[1]));

  // R6
  setup_no_nak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_ev |-> !nak_o);
endmodule

// File: tb/test_ep_handshake_ctrl.sv
`timescale 1ns/1ps
module test_ep_handshake_ctrl;
  localparam int unsigned NUM_EP = 4;
  localparam int unsigned IDX_W  = 2;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             bus_reset_i = 1'b0;
  logic             cfg_we_i = 1'b0;
  logic [1:0]       cfg_data_i = '0;
  logic             cmd_valid_i = 1'b0;
  logic [2:0]       cmd_op_i = '0;
  logic [IDX_W-1:0] cmd_ep_i = '0;
  logic [2:0]       status_o;
  logic             sie_valid_i = 1'b0;
  logic [IDX_W-1:0] sie_ep_i = '0;
  logic             sie_setup_i = 1'b0;
  logic             nak_o;
  logic [NUM_EP-1:0] int_o;
  logic             irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  ep_handshake_ctrl #(.NUM_EP(NUM_EP)) i_ep_handshake_ctrl (.*);

  // row: req[19:16] act[15:14] ep[13:12] arg[11:9] nak[8] chk[7:6] stat[5:3] irq[2]
  // act: 0 cfg write, 1 command, 2 packet event, 3 SETUP
  localparam int NROWS = 40;
  localparam logic [19:0] ROWS [NROWS] = '{
    {4'd2, 2'd0,2'd0,3'd3,1'b0,2'd0,3'b100,1'b0,2'b0}, // R2 reg0 fixed
    {4'd2, 2'd0,2'd0,3'd0,1'b0,2'd1,3'b100,1'b0,2'b0}, // R2 reg1 fixed
    {4'd2, 2'd0,2'd0,3'd1,1'b0,2'd2,3'b100,1'b0,2'b0}, // R2 ep2 rx on
    {4'd2, 2'd0,2'd0,3'd3,1'b0,2'd3,3'b100,1'b0,2'b0}, // R2 ep3 tx on
    {4'd3, 2'd2,2'd2,3'd0,1'b0,2'd2,3'b111,1'b1,2'b0}, // R3 accept
    {4'd3, 2'd2,2'd2,3'd0,1'b1,2'd2,3'b111,1'b1,2'b0}, // R3 full -> NAK
    {4'd8, 2'd1,2'd2,3'd1,1'b0,2'd2,3'b101,1'b0,2'b0}, // R8 read clears int
    {4'd4, 2'd1,2'd2,3'd2,1'b0,2'd2,3'b100,1'b0,2'b0}, // R4 clear
    {4'd4, 2'd2,2'd2,3'd0,1'b0,2'd2,3'b111,1'b1,2'b0}, // R4 next accepted
    {4'd8, 2'd1,2'd2,3'd1,1'b0,2'd2,3'b101,1'b0,2'b0}, // R8
    {4'd5, 2'd2,2'd3,3'd0,1'b1,2'd3,3'b100,1'b0,2'b0}, // R5 not validated
    {4'd5, 2'd1,2'd3,3'd3,1'b0,2'd3,3'b101,1'b0,2'b0}, // R5 validate
    {4'd5, 2'd2,2'd3,3'd0,1'b0,2'd3,3'b110,1'b1,2'b0}, // R5 sent
    {4'd11,2'd1,2'd3,3'd1,1'b0,2'd3,3'b100,1'b0,2'b0}, // R11 irq drops
    {4'd5, 2'd1,2'd1,3'd3,1'b0,2'd1,3'b101,1'b0,2'b0}, // R5 ctrl IN validate
    {4'd6, 2'd3,2'd0,3'd0,1'b0,2'd1,3'b100,1'b1,2'b0}, // R6 IN flushed
    {4'd6, 2'd1,2'd0,3'd0,1'b0,2'd0,3'b111,1'b1,2'b0}, // R6 ep0 full+int
    {4'd7, 2'd1,2'd1,3'd3,1'b0,2'd1,3'b100,1'b1,2'b0}, // R7 validate locked
    {4'd7, 2'd1,2'd0,3'd2,1'b0,2'd0,3'b111,1'b1,2'b0}, // R7 clear locked
    {4'd7, 2'd2,2'd1,3'd0,1'b1,2'd1,3'b100,1'b1,2'b0}, // R7 no reply
    {4'd7, 2'd2,2'd0,3'd0,1'b1,2'd0,3'b111,1'b1,2'b0}, // R7 setup kept
    {4'd6, 2'd3,2'd0,3'd0,1'b0,2'd0,3'b111,1'b1,2'b0}, // R6 setup while full
    {4'd7, 2'd1,2'd0,3'd4,1'b0,2'd0,3'b111,1'b1,2'b0}, // R7 acknowledge
    {4'd7, 2'd1,2'd0,3'd2,1'b0,2'd0,3'b110,1'b1,2'b0}, // R7 clear works
    {4'd8, 2'd1,2'd0,3'd1,1'b0,2'd0,3'b100,1'b0,2'b0}, // R8
    {4'd7, 2'd1,2'd1,3'd3,1'b0,2'd1,3'b101,1'b0,2'b0}, // R7 validate works
    {4'd5, 2'd2,2'd1,3'd0,1'b0,2'd1,3'b110,1'b1,2'b0}, // R5 ctrl IN sent
    {4'd11,2'd1,2'd1,3'd1,1'b0,2'd1,3'b100,1'b0,2'b0}, // R11
    {4'd2, 2'd0,2'd0,3'd0,1'b0,2'd0,3'b100,1'b0,2'b0}, // R2 wrap to reg0
    {4'd2, 2'd0,2'd0,3'd0,1'b0,2'd1,3'b100,1'b0,2'b0}, // R2
    {4'd10,2'd0,2'd0,3'd0,1'b0,2'd2,3'b000,1'b0,2'b0}, // R10 ep2 off
    {4'd10,2'd2,2'd2,3'd0,1'b1,2'd2,3'b000,1'b0,2'b0}, // R10 NAK, no int
    {4'd10,2'd0,2'd0,3'd2,1'b0,2'd3,3'b000,1'b0,2'b0}, // R10 ep3 off (tx)
    {4'd10,2'd1,2'd3,3'd3,1'b0,2'd3,3'b000,1'b0,2'b0}, // R10 validate off ep
    {4'd2, 2'd0,2'd0,3'd0,1'b0,2'd0,3'b100,1'b0,2'b0}, // R2
    {4'd2, 2'd0,2'd0,3'd0,1'b0,2'd1,3'b100,1'b0,2'b0}, // R2
    {4'd2, 2'd0,2'd0,3'd0,1'b0,2'd2,3'b000,1'b0,2'b0}, // R2
    {4'd2, 2'd0,2'd0,3'd3,1'b0,2'd3,3'b100,1'b0,2'b0}, // R2 ep3 back on
    {4'd10,2'd2,2'd3,3'd0,1'b1,2'd3,3'b100,1'b0,2'b0}, // R10 validate was lost
    {4'd10,2'd1,2'd2,3'd1,1'b0,2'd2,3'b000,1'b0,2'b0}  // R10 read off ep
  };

  task automatic check(input int req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input logic [IDX_W-1:0] ep);
    cfg_we_i = 1'b0; cmd_valid_i = 1'b0; cmd_op_i = 3'd0; cmd_ep_i = ep;
    sie_valid_i = 1'b0; sie_setup_i = 1'b0; bus_reset_i = 1'b0;
  endtask

  task automatic look(input int req, input logic [IDX_W-1:0] ep,
                      input logic [2:0] st, input logic irq);
    cmd_ep_i = ep;
    #1;
    check(req, "status", int'(status_o), int'(st));
    check(req, "irq", int'(irq_o), int'(irq));
  endtask

  task automatic cmd(input logic [2:0] op, input logic [IDX_W-1:0] ep);
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_ep_i = ep;
    @(negedge clk_i);
    idle(ep);
  endtask

  initial begin
    idle('0);
    #9 rst_ni = 1'b1;
    // R1 state after power-on reset
    @(negedge clk_i);
    look(1, 2'd0, 3'b100, 1'b0);
    look(1, 2'd1, 3'b100, 1'b0);
    look(1, 2'd2, 3'b000, 1'b0);
    look(1, 2'd3, 3'b000, 1'b0);
    check(1, "nak idle", int'(nak_o), 0);

    for (int r = 0; r < NROWS; r++) begin
      logic [19:0] w;
      w = ROWS[r];
      @(negedge clk_i);
      case (w[15:14])
        2'd0: begin cfg_we_i = 1'b1; cfg_data_i = w[10:9]; end
        2'd1: begin cmd_valid_i = 1'b1; cmd_op_i = w[11:9]; cmd_ep_i = w[13:12]; end
        2'd2: begin sie_valid_i = 1'b1; sie_ep_i = w[13:12]; end
        default: begin sie_valid_i = 1'b1; sie_setup_i = 1'b1; sie_ep_i = '0; end
      endcase
      #1;
      check(int'(w[19:16]), "nak", int'(nak_o), int'(w[8]));
      @(negedge clk_i);
      idle(w[7:6]);
      look(int'(w[19:16]), w[7:6], w[5:3], w[2]);
    end

    // R9 event and read on the same endpoint in one cycle
    cmd(3'd3, 2'd3);
    @(negedge clk_i);
    sie_valid_i = 1'b1; sie_ep_i = 2'd3;
    cmd_valid_i = 1'b1; cmd_op_i = 3'd1; cmd_ep_i = 2'd3;
    @(negedge clk_i);
    idle(2'd3);
    look(9, 2'd3, 3'b110, 1'b1);
    cmd(3'd1, 2'd3);
    look(9, 2'd3, 3'b100, 1'b0);

    // R1 bus reset while SETUP lock held
    @(negedge clk_i);
    sie_valid_i = 1'b1; sie_setup_i = 1'b1; sie_ep_i = '0;
    @(negedge clk_i);
    idle('0);
    look(6, 2'd0, 3'b111, 1'b1);
    @(negedge clk_i);
    bus_reset_i = 1'b1;
    @(negedge clk_i);
    idle('0);
    look(1, 2'd0, 3'b100, 1'b0);
    look(1, 2'd1, 3'b100, 1'b0);
    look(1, 2'd3, 3'b000, 1'b0);
    cmd(3'd3, 2'd1);
    look(1, 2'd1, 3'b101, 1'b0);  // R1 lock released
    // R1 pointer back at reg0: two ignored writes, then ep2 enabled
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      cfg_we_i = 1'b1; cfg_data_i = 2'b01;
    end
    @(negedge clk_i);
    idle(2'd2);
    look(1, 2'd2, 3'b100, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule